// File: doc/BRIEF.md
# Interrupt Moderation Timer Pair

This block sits between a DMA engine's completion events and the interrupt line for one direction of traffic (transmit or receive). Instead of raising an interrupt for every completion, it holds completions as "pending" and releases a single moderated done pulse when one of two timers expires. The burst timer caps how long the first pending completion may wait. The idle timer expires when no further completion has arrived for a programmed gap. Either timer can count core clock cycles or an external one-microsecond strobe. Thresholds are therefore given in microseconds when the strobe is selected.

Software programs each timer through a small write-only port. The expected order is: clear the timer, write its threshold, then write enable together with the strobe select. When neither timer is enabled, the block passes completions straight through, one done pulse per completion. A separate high-water indication, meaning the receive buffer is close to overflow, bypasses moderation. It raises done at once, together with its own risk output, so draining the ring is never delayed.

Top module: `imod_pair`

## Requirements
- R1: After reset, `done_o` and `risk_o` are low and both timers are disabled with a zero count, so the block starts in pass-through mode.
- R2: A write to a control address (`cfg_addr` 0 = burst control, 2 = idle control) decodes `cfg_wdata` bit 0 as clear, bit 1 as enable and bit 2 as strobe select. With bit 0 set, the timer becomes disabled with strobe select off, whatever the other bits hold. Every control write zeroes that timer's count.
- R3: A threshold write (`cfg_addr` 1 = burst, 3 = idle) takes effect only while that timer is disabled. While the timer is enabled, the write is ignored and later expiries keep the old threshold.
- R4: With both timers disabled, every completion sampled on a clock edge gives a one-cycle `done_o` pulse right after that edge.
- R5: With the burst timer enabled at threshold T (T > 0), counting every cycle, a completion that finds nothing pending and is sampled at edge c produces `done_o` after edge c+T. Completions arriving in between do not move this deadline.
- R6: With the idle timer enabled at threshold T (T > 0), counting every cycle, each completion restarts the idle count. `done_o` follows edge c+T, where c is the edge of the last completion, unless a newer completion arrives first.
- R7: With strobe select set, a timer advances only on edges where `us_tick_i` is high; on other edges its count holds.
- R8: A threshold of zero on an enabled timer makes `done_o` follow the very edge on which a completion is sampled.
- R9: Every `done_o` pulse lasts exactly one cycle unless a new expiry follows immediately. Each pulse clears the pending state and both counts, and `done_o` never rises without a completion or high-water event behind it.
- R10: A high `hi_water_i` sampled on an edge makes both `risk_o` and `done_o` high after that edge in every mode, and flushes any pending work.
- R11: With both timers enabled, the first one to expire raises `done_o` and restarts both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 burst control, 1 burst threshold, 2 idle control, 3 idle threshold |
| cfg_wdata | input | CNT_W | Write data (control bits or threshold) |
| cmpl_i | input | 1 | Raw completion event, one per cycle at most |
| us_tick_i | input | 1 | One-cycle microsecond strobe |
| hi_water_i | input | 1 | Receive buffer at risk of overflow |
| done_o | output | 1 | Moderated done interrupt request |
| risk_o | output | 1 | Registered overflow-risk indication |

## Verification
The embedded properties rely on all inputs being synchronous to `clk` and on `us_tick_i` being a strobe that is sampled on edges, not a level that carries meaning of its own. They also rely on configuration writes and completions being single-cycle events. The bound on the count against the threshold is only meaningful because software cannot change the threshold of a running timer. The bench drives every input on the falling edge. It issues each register write as its own one-cycle strobe and keeps the microsecond strobe one cycle wide. It exercises thresholds far below the counter's saturation value, so the saturating increment never decides an expiry.

// File: rtl/imod_pkg.sv
package imod_pkg;

  localparam int N_TMR        = 2;
  localparam int CTL_CLR_BIT  = 0;
  localparam int CTL_EN_BIT   = 1;
  localparam int CTL_TSEL_BIT = 2;

  typedef enum logic {
    TMR_BURST = 1'b0,
    TMR_IDLE  = 1'b1
  } tmr_kind_e;

  typedef struct packed {
    logic en;
    logic tsel;
  } tmr_ctl_t;

endpackage

// File: rtl/imod_timer.sv
module imod_timer
  import imod_pkg::*;
#(
  parameter int        CNT_W = 16,
  parameter tmr_kind_e KIND  = TMR_BURST
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we_i,
  input  logic             thr_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             cmpl_i,
  input  logic             pend_now_i,
  input  logic             fire_i,
  input  logic             tick_i,
  output logic             hit_o,
  output logic             en_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam bit               RESTART = (KIND == TMR_IDLE);

  function automatic logic may_step(input logic tsel, input logic tick);
    return tsel ? tick : 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + CNT_ONE;
  endfunction

  tmr_ctl_t         ctl_q;
  logic [CNT_W-1:0] thr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_eff;
  logic             adv;
  logic             restart;

  assign adv     = may_step(ctl_q.tsel, tick_i);
  assign restart = RESTART && cmpl_i;
  assign cnt_eff = restart ? '0 : cnt_q;
  assign hit_o   = ctl_q.en && pend_now_i && (cnt_eff >= thr_q);
  assign en_o    = ctl_q.en;

  always_comb begin
    cnt_d = cnt_q;
    if (ctl_we_i || !ctl_q.en || fire_i)
      cnt_d = '0;
    else if (restart)
      cnt_d = adv ? CNT_ONE : '0;
    else if (pend_now_i && adv)
      cnt_d = sat_inc(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      thr_q <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (ctl_we_i) begin
        if (wdata_i[CTL_CLR_BIT]) begin
          ctl_q <= '0;
        end else begin
          ctl_q.en   <= wdata_i[CTL_EN_BIT];
          ctl_q.tsel <= wdata_i[CTL_TSEL_BIT];
        end
      end
      if (thr_we_i && !ctl_q.en)
        thr_q <= wdata_i;
    end
  end

  // R2: a disabled timer always rests at zero
  assert_off_count_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.en |-> (cnt_q == '0));

  // R3: threshold cannot move under a running timer
  assert_thr_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.en && $past(ctl_q.en)) |-> $stable(thr_q));

  // R5: a running count never passes its threshold
  assert_cnt_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.en |-> (cnt_q <= thr_q));

  // R7: with strobe select, no strobe means no advance
  assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.en && ctl_q.tsel && !tick_i && !ctl_we_i && !fire_i && !cmpl_i)
      |=> $stable(cnt_q));

endmodule

// File: rtl/imod_combine.sv
module imod_combine
  import imod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmpl_i,
  input  logic             hw_i,
  input  logic [N_TMR-1:0] hit_i,
  input  logic [N_TMR-1:0] en_i,
  output logic             pend_now_o,
  output logic             fire_o,
  output logic             done_o,
  output logic             risk_o
);

  logic pend_q;
  logic mod_on;
  logic tmr_fire;

  assign mod_on     = |en_i;
  assign tmr_fire   = |hit_i;
  assign pend_now_o = pend_q | cmpl_i;
  assign fire_o     = hw_i | (mod_on ? tmr_fire : cmpl_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_o <= 1'b0;
      risk_o <= 1'b0;
    end else begin
      pend_q <= mod_on & pend_now_o & ~fire_o;
      done_o <= fire_o;
      risk_o <= hw_i;
    end
  end

  // R4: pass-through when moderation is off
  assert_raw_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_on && cmpl_i) |=> done_o);

  // R10: overflow risk bypasses moderation
  assert_hw_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hw_i |=> (done_o && risk_o));

  // R9: a done pulse leaves nothing pending
  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !pend_q);

  // R9: no done without a cause
  assert_done_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(pend_now_o || hw_i));

endmodule

// File: rtl/imod_pair.sv
module imod_pair
  import imod_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             cmpl_i,
  input  logic             us_tick_i,
  input  logic             hi_water_i,
  output logic             done_o,
  output logic             risk_o
);

  logic [N_TMR-1:0] hit;
  logic [N_TMR-1:0] en;
  logic             pend_now;
  logic             fire;

  for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
    localparam logic      SEL  = 1'(k);
    localparam tmr_kind_e KIND = (k == 0) ? TMR_BURST : TMR_IDLE;
    logic ctl_we;
    logic thr_we;

    assign ctl_we = cfg_we && (cfg_addr[1] == SEL) && !cfg_addr[0];
    assign thr_we = cfg_we && (cfg_addr[1] == SEL) &&  cfg_addr[0];

    imod_timer #(.CNT_W(CNT_W), .KIND(KIND)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_we_i   (ctl_we),
      .thr_we_i   (thr_we),
      .wdata_i    (cfg_wdata),
      .cmpl_i     (cmpl_i),
      .pend_now_i (pend_now),
      .fire_i     (fire),
      .tick_i     (us_tick_i),
      .hit_o      (hit[k]),
      .en_o       (en[k])
    );
  end

  imod_combine u_comb (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmpl_i     (cmpl_i),
    .hw_i       (hi_water_i),
    .hit_i      (hit),
    .en_i       (en),
    .pend_now_o (pend_now),
    .fire_o     (fire),
    .done_o     (done_o),
    .risk_o     (risk_o)
  );

endmodule

// File: tb/sim_imod_pair.sv
module sim_imod_pair;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we;
  logic [1:0]       cfg_addr;
  logic [CNT_W-1:0] cfg_wdata;
  logic             cmpl_i, us_tick_i, hi_water_i;
  logic             done_o, risk_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  imod_pair #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cmpl_i(cmpl_i), .us_tick_i(us_tick_i),
    .hi_water_i(hi_water_i), .done_o(done_o), .risk_o(risk_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R1";
  bit    running = 0;
  bit    finished = 0;

  // behavioural reference: index 0 = burst, 1 = idle
  int m_on[2], m_usec[2], m_limit[2], m_age[2];
  bit m_waiting, x_done, x_risk;

  always @(posedge clk) begin : ref_model
    bit moderated, any_pend, go, adv, exp_now;
    int age_seen;
    if (!rst_n) begin
      foreach (m_on[i]) begin m_on[i] = 0; m_usec[i] = 0; m_limit[i] = 0; m_age[i] = 0; end
      m_waiting = 0; x_done = 0; x_risk = 0;
    end else begin
      moderated = (m_on[0] != 0) || (m_on[1] != 0);
      any_pend  = m_waiting || cmpl_i;
      go = hi_water_i;
      if (!moderated) go = go || cmpl_i;
      else begin
        for (int i = 0; i < 2; i++) begin
          age_seen = (i == 1 && cmpl_i) ? 0 : m_age[i];
          exp_now  = (m_on[i] != 0) && any_pend && (age_seen >= m_limit[i]);
          go = go || exp_now;
        end
      end
      for (int i = 0; i < 2; i++) begin
        adv = (m_usec[i] != 0) ? us_tick_i : 1'b1;
        if ((cfg_we && cfg_addr == 2'(2*i)) || m_on[i] == 0 || go) m_age[i] = 0;
        else if (i == 1 && cmpl_i) m_age[i] = adv ? 1 : 0;
        else if (any_pend && adv && m_age[i] < 65535) m_age[i] = m_age[i] + 1;
      end
      m_waiting = moderated && any_pend && !go;
      x_done = go;
      x_risk = hi_water_i;
      if (cfg_we) begin
        int t;
        t = cfg_addr[1];
        if (!cfg_addr[0]) begin
          if (cfg_wdata[0]) begin m_on[t] = 0; m_usec[t] = 0; end
          else begin m_on[t] = cfg_wdata[1]; m_usec[t] = cfg_wdata[2]; end
        end else if (m_on[t] == 0) m_limit[t] = int'(cfg_wdata);
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      n_cmp++;
      if (done_o !== x_done || risk_o !== x_risk) begin
        n_bad++;
        $display("FAIL %s: done/risk actual %b/%b expected %b/%b at %0t",
                 phase, done_o, risk_o, x_done, x_risk, $time);
      end
    end
  end

  task automatic cyc(input bit c, input bit t, input bit h);
    @(negedge clk);
    cfg_we = 0; cmpl_i = c; us_tick_i = t; hi_water_i = h;
  endtask

  task automatic idle(input int n);
    repeat (n) cyc(0, 0, 0);
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = CNT_W'(d);
    cmpl_i = 0; us_tick_i = 0; hi_water_i = 0;
  endtask

  task automatic spaced(input int gap, input int count);
    for (int i = 0; i < count; i++) begin
      cyc(1, 0, 0);
      idle(gap - 1);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R9: watchdog actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    cmpl_i = 0; us_tick_i = 0; hi_water_i = 0;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (done_o !== 1'b0 || risk_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: reset outputs actual %b/%b expected 0/0", done_o, risk_o);
    end
    rst_n = 1;
    running = 1;
    phase = "R1"; idle(3);

    phase = "R4"; cyc(1, 0, 0); idle(2); spaced(1, 3); idle(3);

    phase = "R2"; wr(0, 1); wr(1, 5); wr(0, 2); idle(2);
    phase = "R5"; cyc(1, 0, 0); idle(10); spaced(1, 8); idle(8);
    spaced(3, 4); idle(8);
    phase = "R3"; wr(1, 2); cyc(1, 0, 0); idle(8);
    phase = "R2"; wr(0, 7); spaced(2, 3); idle(3);
    wr(0, 2); cyc(1, 0, 0); idle(2); wr(0, 1); idle(6);

    phase = "R6"; wr(2, 1); wr(3, 4); wr(2, 2); idle(2);
    spaced(2, 5); idle(8); spaced(5, 3); idle(8);

    phase = "R7"; wr(2, 1); wr(3, 3); wr(2, 6);
    for (int i = 0; i < 40; i++) cyc(i == 0 || i == 10, (i % 3) == 2, 0);
    idle(4);

    phase = "R8"; wr(2, 1); wr(0, 1); wr(1, 0); wr(0, 2);
    cyc(1, 0, 0); idle(2); spaced(1, 4); idle(3);

    phase = "R11"; wr(0, 1); wr(1, 6); wr(0, 2); wr(2, 1); wr(3, 2); wr(2, 2);
    cyc(1, 0, 0); idle(5); spaced(1, 10); idle(8); spaced(2, 6); idle(8);

    phase = "R10"; cyc(1, 0, 0); cyc(0, 0, 1); idle(8);
    cyc(0, 0, 1); idle(2); wr(0, 1); wr(2, 1); cyc(0, 0, 1); cyc(1, 0, 1); idle(3);
    wr(0, 6);

    phase = "R9";
    for (int i = 0; i < 600; i++) begin
      if (i == 200) begin wr(2, 1); wr(3, 3); wr(2, 2); end
      if (i == 400) begin wr(0, 1); wr(2, 1); end
      cyc($urandom_range(99) < 30, $urandom_range(99) < 50, $urandom_range(99) < 3);
    end
    idle(10);

    running = 0;
    finished = 1;
    summary();
    $finish;
  end

endmodule